// File: doc/BRIEF.md
# Encoded High/Low-Time Clock Divider

This block divides an input clock by a ratio N from 1 to 128. The ratio is not given as a plain integer. It arrives as a 14-bit control word that holds four things: a count of input cycles for the output's high phase, a count for the low phase, a flag that adds a half-cycle extension for odd ratios, and a bypass flag that selects divide-by-one. The block checks every word it is given and raises an error flag one clock later if the word does not describe a legal ratio.

The ratio is taken from the word only on the clock edge where the enable is first seen high. A new word has no effect until the enable is dropped and raised again. While the enable is low, the output is held low and the phase counters are cleared.

A separate combinational helper turns an integer ratio into the control word. It also produces the 24-bit packed form of that word, in which the two flags sit at bits 22 and 23. A test environment can use the helper to sweep ratios.

Top module: `hlclk_divider`

## Requirements
- R1: The helper encodes every ratio from 1 to 128. A ratio of 0, or any ratio above 128, gives the error word 0x3000, which has both flag bits (12 and 13) set and all count bits zero.
- R2: Word layout: the low-phase count is in bits 5:0, the high-phase count in bits 11:6, the bypass flag in bit 12 and the edge flag in bit 13. For N of 2 or more, the high count is floor(N/2). The low count equals the high count for even N and is one more for odd N. The edge flag is set only for odd N. A count of 64 is written as field value 0.
- R3: With a legal word for N of 2 or more and the enable high, the output period is N input cycles. The output is high for floor(N/2) cycles, plus half an input cycle when the edge flag is set.
- R4: The divide-by-one word is 0x1041 (bypass set, high count 1, low count 1). With this word the output follows the input clock: it has the input period and is high for half an input cycle.
- R5: The helper's packed form keeps bits 11:0 of the word in place, moves the bypass flag to bit 22 and the edge flag to bit 23, and leaves every other bit zero. The error word packs to 0xC00000.
- R6: From the first clock edge at which the enable is sampled low, the output stays low. When the enable is raised again, counting restarts from the beginning of a high phase.
- R7: The error output reflects the word sampled at the previous clock edge. It is 1 for any of these words: both flags set; the bypass flag set with either count other than 1; a low count not equal to the high count when the edge flag is clear; a low count not equal to the high count plus one when the edge flag is set.
- R8: If the word is illegal on the edge where the enable is first seen high, the output stays low for as long as the enable remains high.
- R9: The word is captured on the first enabled clock edge. A change to the word while the enable stays high has no effect on the output until the enable has been low for at least one clock edge.
- R10: After synchronous reset, the output is low and the error output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; the word is captured on the first edge at which it is seen high |
| word_i | input | 14 | Encoded control word (counts, bypass flag, edge flag) |
| div_clk_o | output | 1 | Divided clock output |
| cfg_err_o | output | 1 | Registered flag: the word sampled at the previous edge is illegal |

## Verification
The error flag is due one rising edge after a word is applied. The bench drives each word on a falling edge and samples the flag on the next falling edge. The divided output starts its first high phase on the first rising edge at which the enable is seen high. Its half-cycle extension ends on the falling edge that follows the end of the high count. For this reason the bench times the output edges with simulation time instead of sampling at clock edges. It waits 3N+6 input cycles so that at least three rising edges of the output have occurred, and takes the period and the high time from a complete pulse. Checks that the output is held low, or that an illegal word has no effect, are sampled at falling edges, starting one full cycle after the enable drops or the word is applied.

// File: rtl/hlclk_pkg.sv
package hlclk_pkg;

    localparam int CNT_W     = 6;
    localparam int LEN_W     = CNT_W + 1;
    localparam int WORD_W    = 2 * CNT_W + 2;
    localparam int BYP_BIT   = 2 * CNT_W;
    localparam int EDGE_BIT  = 2 * CNT_W + 1;
    localparam int RATIO_MAX = 1 << LEN_W;
    localparam int RATIO_W   = LEN_W + 1;
    localparam int PK_W      = 24;
    localparam int PK_BYP    = 22;
    localparam int PK_EDGE   = 23;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic             valid;
        logic             bypass;
        logic             edge_f;
        logic [LEN_W-1:0] hi_len;
        logic [LEN_W-1:0] lo_len;
    } cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HIGH,
        ST_LOW,
        ST_BYP,
        ST_HALT
    } state_t;

    // A zero field stands for the largest count, half the largest ratio.
    function automatic logic [LEN_W-1:0] field_len(input logic [CNT_W-1:0] f);
        if (f == '0)
            return LEN_W'(RATIO_MAX / 2);
        return {1'b0, f};
    endfunction

    function automatic cfg_t decode_word(input word_t w);
        cfg_t c;
        logic [CNT_W-1:0] hf;
        logic [CNT_W-1:0] lf;
        hf       = w[2*CNT_W-1:CNT_W];
        lf       = w[CNT_W-1:0];
        c.bypass = w[BYP_BIT];
        c.edge_f = w[EDGE_BIT];
        c.hi_len = field_len(hf);
        c.lo_len = field_len(lf);
        if (c.bypass && c.edge_f)
            c.valid = 1'b0;
        else if (c.bypass)
            c.valid = (hf == CNT_W'(1)) && (lf == CNT_W'(1));
        else if (c.edge_f)
            c.valid = (c.lo_len == c.hi_len + LEN_W'(1));
        else
            c.valid = (c.lo_len == c.hi_len);
        return c;
    endfunction

    function automatic word_t encode_ratio(input logic [RATIO_W-1:0] n);
        word_t              w;
        logic [RATIO_W-1:0] h;
        logic [RATIO_W-1:0] l;
        w = '0;
        h = n >> 1;
        l = h + RATIO_W'(n[0]);
        if (n == '0 || n > RATIO_W'(RATIO_MAX)) begin
            w[BYP_BIT]  = 1'b1;
            w[EDGE_BIT] = 1'b1;
        end else if (n == RATIO_W'(1)) begin
            w[BYP_BIT] = 1'b1;
            w[CNT_W]   = 1'b1;
            w[0]       = 1'b1;
        end else begin
            w[2*CNT_W-1:CNT_W] = h[CNT_W-1:0];
            w[CNT_W-1:0]       = l[CNT_W-1:0];
            w[EDGE_BIT]        = n[0];
        end
        return w;
    endfunction

    function automatic logic [PK_W-1:0] pack_count(input word_t w);
        logic [PK_W-1:0] p;
        p              = '0;
        p[2*CNT_W-1:0] = w[2*CNT_W-1:0];
        p[PK_BYP]      = w[BYP_BIT];
        p[PK_EDGE]     = w[EDGE_BIT];
        return p;
    endfunction

endpackage

// File: rtl/hlclk_ratio_enc.sv
module hlclk_ratio_enc
    import hlclk_pkg::*;
(
    input  logic [RATIO_W-1:0] ratio_i,
    output logic [WORD_W-1:0]  word_o,
    output logic [PK_W-1:0]    packed_o
);
    always_comb begin
        word_o   = encode_ratio(ratio_i);
        packed_o = pack_count(word_o);
    end
endmodule

// File: rtl/hlclk_word_dec.sv
module hlclk_word_dec
    import hlclk_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  word_t word_i,
    output cfg_t  cfg_o,
    output logic  err_o
);
    always_comb cfg_o = decode_word(word_i);

    always_ff @(posedge clk_i) begin
        if (rst_i)
            err_o <= 1'b0;
        else
            err_o <= !cfg_o.valid;
    end
endmodule

// File: rtl/hlclk_phase_gen.sv
module hlclk_phase_gen
    import hlclk_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   en_i,
    input  cfg_t   cfg_i,
    output state_t state_o,
    output logic   pos_o,
    output cfg_t   cfg_q_o
);
    logic [LEN_W-1:0] cnt;

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) begin
            state_o <= ST_IDLE;
            pos_o   <= 1'b0;
            cnt     <= '0;
            cfg_q_o <= '0;
        end else begin
            case (state_o)
                ST_IDLE: begin
                    cfg_q_o <= cfg_i;
                    if (!cfg_i.valid) begin
                        state_o <= ST_HALT;
                    end else if (cfg_i.bypass) begin
                        state_o <= ST_BYP;
                    end else begin
                        state_o <= ST_HIGH;
                        pos_o   <= 1'b1;
                        cnt     <= LEN_W'(1);
                    end
                end
                ST_HIGH: begin
                    if (cnt == cfg_q_o.hi_len) begin
                        state_o <= ST_LOW;
                        pos_o   <= 1'b0;
                        cnt     <= LEN_W'(1);
                    end else begin
                        cnt <= cnt + LEN_W'(1);
                    end
                end
                ST_LOW: begin
                    if (cnt == cfg_q_o.lo_len) begin
                        state_o <= ST_HIGH;
                        pos_o   <= 1'b1;
                        cnt     <= LEN_W'(1);
                    end else begin
                        cnt <= cnt + LEN_W'(1);
                    end
                end
                default: begin
                    state_o <= state_o;
                end
            endcase
        end
    end
endmodule

// File: rtl/hlclk_half_stretch.sv
module hlclk_half_stretch (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pos_i,
    input  logic edge_i,
    input  logic byp_i,
    output logic out_o
);
    logic neg_q;

    always_ff @(negedge clk_i) begin
        if (rst_i)
            neg_q <= 1'b0;
        else
            neg_q <= pos_i;
    end

    assign out_o = (byp_i & clk_i) | pos_i | (edge_i & neg_q);
endmodule

// File: rtl/hlclk_divider.sv
module hlclk_divider
    import hlclk_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              div_clk_o,
    output logic              cfg_err_o
);
    cfg_t   cfg_w;
    cfg_t   cfg_q_w;
    state_t state_w;
    logic   pos_w;

    hlclk_word_dec u_dec (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .word_i (word_i),
        .cfg_o  (cfg_w),
        .err_o  (cfg_err_o)
    );

    hlclk_phase_gen u_gen (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (en_i),
        .cfg_i   (cfg_w),
        .state_o (state_w),
        .pos_o   (pos_w),
        .cfg_q_o (cfg_q_w)
    );

    hlclk_half_stretch u_str (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .pos_i  (pos_w),
        .edge_i (cfg_q_w.edge_f),
        .byp_i  (state_w == ST_BYP),
        .out_o  (div_clk_o)
    );
endmodule

// File: rtl/hlclk_divider_chk.sv
module hlclk_divider_chk
    import hlclk_pkg::*;
(
    input logic   clk_i,
    input logic   rst_i,
    input logic   en_i,
    input state_t state_i,
    input logic   pos_i,
    input cfg_t   cfg_i
);
    logic [LEN_W:0] hi_run;

    always_ff @(posedge clk_i) begin
        if (rst_i || !pos_i)
            hi_run <= '0;
        else
            hi_run <= hi_run + (LEN_W+1)'(1);
    end

    // R6
    idle_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> !pos_i);

    // R3
    high_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_LOW && $past(state_i) == ST_HIGH)
            |-> (hi_run == (LEN_W+1)'(cfg_i.hi_len)));

    // R9
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && state_i != ST_IDLE) |=> (state_i == ST_IDLE || $stable(cfg_i)));

    // R8
    run_valid_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_HIGH || state_i == ST_LOW || state_i == ST_BYP)
            |-> cfg_i.valid);

    // R4
    byp_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_BYP) |-> !pos_i);
endmodule

bind hlclk_divider hlclk_divider_chk u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .en_i    (en_i),
    .state_i (state_w),
    .pos_i   (pos_w),
    .cfg_i   (cfg_q_w)
);

// File: tb/hlclk_divider_bench.sv
`timescale 1ns/1ps
module hlclk_divider_bench;
    import hlclk_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic               rst;
    logic               en;
    word_t              word;
    logic               div_clk;
    logic               err;
    logic [RATIO_W-1:0] ratio;
    word_t              enc_word;
    logic [PK_W-1:0]    enc_pk;

    int checks = 0;
    int fails  = 0;

    realtime rise_t = 0.0;
    realtime fall_t = 0.0;
    realtime per_m  = 0.0;
    realtime hi_m   = 0.0;
    int      rises  = 0;

    hlclk_divider u_hlclk_divider (
        .clk_i     (clk),
        .rst_i     (rst),
        .en_i      (en),
        .word_i    (word),
        .div_clk_o (div_clk),
        .cfg_err_o (err)
    );

    hlclk_ratio_enc u_enc (
        .ratio_i  (ratio),
        .word_o   (enc_word),
        .packed_o (enc_pk)
    );

    always @(posedge div_clk) begin
        if (rises > 0) begin
            per_m = $realtime - rise_t;
            hi_m  = fall_t - rise_t;
        end
        rise_t = $realtime;
        rises  = rises + 1;
    end

    always @(negedge div_clk) fall_t = $realtime;

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    function automatic longint ps(input realtime t);
        return longint'(t * 1000.0);
    endfunction

    // Expected word built from the field layout of R1/R2.
    function automatic longint exp_word(input int n);
        int h;
        int l;
        if (n < 1 || n > 128) return 'h3000;
        if (n == 1) return 'h1041;
        h = n / 2;
        l = h + (n % 2);
        return ((n % 2) << 13) | ((h % 64) << 6) | (l % 64);
    endfunction

    task automatic t_reset();
        rst = 1'b1; en = 1'b0; word = '0; ratio = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 output low after reset", div_clk, 0);
        check("R10 error low after reset", err, 0);
    endtask

    task automatic t_encoder();
        for (int n = 0; n <= 130; n++) begin
            ratio = RATIO_W'(n);
            #1;
            if (n == 0 || n > 128)
                check($sformatf("R1 error word ratio %0d", n), enc_word, exp_word(n));
            else
                check($sformatf("R2 word ratio %0d", n), enc_word, exp_word(n));
        end
        ratio = RATIO_W'(1);   #1; check("R4 divide-by-one word", enc_word, 'h1041);
        ratio = RATIO_W'(1);   #1; check("R5 packed ratio 1", enc_pk, 'h400041);
        ratio = RATIO_W'(3);   #1; check("R5 packed ratio 3", enc_pk, 'h800042);
        ratio = RATIO_W'(127); #1; check("R5 packed ratio 127", enc_pk, 'h800FC0);
        ratio = RATIO_W'(128); #1; check("R5 packed ratio 128", enc_pk, 'h000000);
        ratio = RATIO_W'(0);   #1; check("R5 packed error word", enc_pk, 'hC00000);
    endtask

    task automatic run_ratio(input int n, output longint per, output longint hi, output int seen);
        @(negedge clk);
        ratio = RATIO_W'(n);
        #1;
        word  = enc_word;
        rises = 0;
        en    = 1'b1;
        repeat (3 * n + 6) @(negedge clk);
        per  = ps(per_m);
        hi   = ps(hi_m);
        seen = rises;
        en   = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_sweep();
        longint per;
        longint hi;
        int     seen;
        for (int n = 1; n <= 128; n++) begin
            run_ratio(n, per, hi, seen);
            if (n == 1) begin
                check("R4 bypass period", per, 4000);
                check("R4 bypass high time", hi, 2000);
            end else begin
                check($sformatf("R3 period ratio %0d", n), per, 4000 * n);
                check($sformatf("R3 high time ratio %0d", n), hi,
                      4000 * (n / 2) + ((n % 2) ? 2000 : 0));
            end
            check($sformatf("R3 pulses seen ratio %0d", n), seen >= 3, 1);
        end
    endtask

    task automatic t_disable();
        int  high_seen;
        longint per;
        longint hi;
        int seen;
        @(negedge clk);
        ratio = RATIO_W'(5);
        #1;
        word = enc_word;
        en   = 1'b1;
        repeat (13) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        high_seen = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (div_clk) high_seen++;
            #1;
            if (div_clk) high_seen++;
            @(posedge clk);
            #1;
            if (div_clk) high_seen++;
        end
        check("R6 output held low while disabled", high_seen, 0);
        run_ratio(7, per, hi, seen);
        check("R6 period after re-enable", per, 28000);
        check("R6 high time after re-enable", hi, 14000);
    endtask

    task automatic t_invalid();
        word_t bad [5];
        bad[0] = 14'h3000;
        bad[1] = 14'h1042;
        bad[2] = 14'h0043;
        bad[3] = 14'h2041;
        bad[4] = 14'h0042;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            word = bad[i];
            @(negedge clk);
            check($sformatf("R7 error for word 0x%0h", bad[i]), err, 1);
        end
        @(negedge clk);
        word = 14'h2042;
        @(negedge clk);
        check("R7 no error for legal word 0x2042", err, 0);
        @(negedge clk);
        word = 14'h1043;
        @(negedge clk);
        check("R7 error for bypass word 0x1043", err, 1);
        rises = 0;
        en    = 1'b1;
        repeat (20) @(negedge clk);
        check("R8 no output pulses for illegal word", rises, 0);
        check("R8 output low for illegal word", div_clk, 0);
        word = 14'h0041;
        repeat (10) @(negedge clk);
        check("R8 legal word ignored until re-enable", rises, 0);
        en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_hold();
        @(negedge clk);
        ratio = RATIO_W'(6);
        #1;
        word  = enc_word;
        rises = 0;
        en    = 1'b1;
        repeat (10) @(negedge clk);
        ratio = RATIO_W'(10);
        #1;
        word = enc_word;
        repeat (60) @(negedge clk);
        check("R9 period unchanged after word change", ps(per_m), 24000);
        check("R9 high time unchanged after word change", ps(hi_m), 12000);
        en = 1'b0;
        repeat (2) @(negedge clk);
        rises = 0;
        en    = 1'b1;
        repeat (40) @(negedge clk);
        check("R9 new period after re-enable", ps(per_m), 40000);
        check("R9 new high time after re-enable", ps(hi_m), 20000);
        en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_encoder();
        t_sweep();
        t_disable();
        t_invalid();
        t_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule